// File: doc/BRIEF.md
# Coherent Time Register Shadow Buffer

This block stands between the register side of a serial bus engine and a free-running BCD time counter. It does two jobs. First, a read freezes a full copy of the time at the moment the bus engine signals that data output is about to begin. Every byte of that read comes from the frozen copy, so a seconds carry cannot split a multi-byte read. Second, a write opens a staging buffer that is loaded from the live time. The incoming bytes then overwrite the staging buffer one position at a time. The live counter receives the whole buffer in one cycle, but only when the transaction ends with a valid stop and the register write-enable latch is set. The counter keeps counting on its one-second tick throughout both kinds of transaction.

The bus engine supplies single-cycle strobes: read-latch, write-start, byte-write (with a byte index and data), valid-stop and abort. It also supplies the level of the write-enable latch. The time is eight BCD bytes, indexed as follows: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 month, 5 year, 6 day of week, 7 century. Only the seconds, minutes, hours, day-of-month and day-of-week bytes count. The month, year and century bytes change only through a write.

Top module: `tkeep_shadow`

## Requirements
- R1: A `rd_latch` pulse copies the live time into the snapshot. From the next cycle, `rd_data` shows snapshot byte `rd_sel`, using the byte order 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 day of week, 7 century.
- R2: The snapshot does not change between `rd_latch` pulses, even while the live time advances.
- R3: Each `tick_1s` advances the live seconds by one in BCD. This holds whether or not a read or write transaction is open.
- R4: Carries ripple as follows. Seconds 59 goes to 00 and carries into minutes. Minutes 59 goes to 00 and carries into hours. Hours 23 goes to 00 and carries into day (31 wraps to 01) and day of week (06 wraps to 00). Month, year and century are never changed by a tick.
- R5: `wr_start` copies the live time into the staging buffer. Each `wr_byte` replaces only staging byte `wr_idx`. On commit, the bytes that were not written take the values they had at `wr_start`.
- R6: `wr_stop_ok` during an open write, with `wr_enable` high, loads the staging buffer into the live time. The load is visible on `live_time` the next cycle.
- R7: `wr_abort` closes the write and discards the buffer. A later `wr_stop_ok` does not change the live time.
- R8: `wr_stop_ok` with `wr_enable` low does not commit, and it closes the write so that the buffer is discarded.
- R9: If a commit and a tick fall in the same cycle, the loaded value is kept and the tick is dropped. The next tick counts up from the loaded value.
- R10: `wr_byte` and `wr_stop_ok` with no open write have no effect on the live time.
- R11: After reset, the live time and the snapshot both read 00:00:00, day 01, month 01, year 00, day of week 00, century 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_latch | input | 1 | Freeze the live time into the snapshot |
| wr_start | input | 1 | Open a write and load the staging buffer from the live time |
| wr_byte | input | 1 | Write `wr_data` into staging byte `wr_idx` |
| wr_idx | input | 3 | Staging byte index |
| wr_data | input | 8 | BCD byte to stage |
| wr_stop_ok | input | 1 | Valid stop ending the transaction |
| wr_abort | input | 1 | Invalid end of transaction; discard the buffer |
| wr_enable | input | 1 | Level of the register write-enable latch |
| tick_1s | input | 1 | One-second count enable |
| rd_sel | input | 3 | Snapshot byte select |
| rd_data | output | 8 | Selected snapshot byte |
| live_time | output | 64 | Live time; byte i is at bits 8i+7..8i |

## Verification
The bench builds the block with its default parameters: day-of-month wrap at 31, day-of-week wrap at 06, and century 20 at reset. These values let a single tick from 23:59:59, day 31, day of week 06 exercise every carry and every wrap in the chain. Ticks are issued inside an open write so that the restored unwritten bytes show up at commit. A commit is also aligned with a tick on the same cycle to check which of the two wins.

// File: rtl/tks_pkg.sv
`timescale 1ns/1ps
// tks_pkg: shared types, byte positions and the BCD step function for the
// time shadow buffer. Assumes eight-bit BCD bytes.
package tks_pkg;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = 8;
    localparam int IDX_W   = $clog2(N_BYTES);
    localparam int TIME_W  = BYTE_W * N_BYTES;

    // Byte positions; the carry chain depends on this order.
    localparam int POS_SEC  = 0;
    localparam int POS_MIN  = 1;
    localparam int POS_HOUR = 2;
    localparam int POS_DAY  = 3;
    localparam int POS_MON  = 4;
    localparam int POS_YEAR = 5;
    localparam int POS_DOW  = 6;
    localparam int POS_CENT = 7;
    localparam int N_CHAIN  = 4;   // sec, min, hour, day form the ripple chain

    typedef logic [BYTE_W-1:0] tbyte_t;
    typedef tbyte_t [N_BYTES-1:0] ttime_t;

    // Next BCD value: wraps to lo after hi, otherwise adds one with a decimal carry.
    function automatic tbyte_t bcd_step(input tbyte_t v, input tbyte_t hi, input tbyte_t lo);
        if (v == hi)
            return lo;
        else if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction
endpackage

// File: rtl/tks_live_ctr.sv
`timescale 1ns/1ps
// tks_live_ctr: the free-running BCD time counter. A load takes priority over
// a tick in the same cycle. Assumes the loaded bytes are valid BCD within
// their ranges; out-of-range values still step by one until they wrap.
module tks_live_ctr
    import tks_pkg::*;
#(
    parameter tbyte_t DAY_HI   = 8'h31,
    parameter tbyte_t DOW_HI   = 8'h06,
    parameter ttime_t RST_TIME = '0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   load,
    input  ttime_t load_val,
    output ttime_t time_q
);
    // Upper and lower wrap values of each chain position.
    function automatic tbyte_t lim_hi(input int g);
        case (g)
            POS_SEC:  return 8'h59;
            POS_MIN:  return 8'h59;
            POS_HOUR: return 8'h23;
            default:  return DAY_HI;
        endcase
    endfunction

    function automatic tbyte_t lim_lo(input int g);
        return (g == POS_DAY) ? 8'h01 : 8'h00;
    endfunction

    logic [N_CHAIN-1:0] carry;
    tbyte_t             rolled [N_CHAIN];
    tbyte_t             dow_next;
    ttime_t             next_t;

    assign carry[0] = tick;

    genvar g;
    generate
        for (g = 0; g < N_CHAIN; g++) begin : g_chain
            // Step one chain byte when its incoming carry is set.
            assign rolled[g] = carry[g] ? bcd_step(time_q[g], lim_hi(g), lim_lo(g)) : time_q[g];
            if (g < N_CHAIN - 1) begin : g_link
                // Pass a carry on when this byte is at its wrap value.
                assign carry[g+1] = carry[g] && (time_q[g] == lim_hi(g));
            end
        end
    endgenerate

    // Day of week steps together with the day of month.
    assign dow_next = carry[POS_DAY] ? bcd_step(time_q[POS_DOW], DOW_HI, 8'h00) : time_q[POS_DOW];

    // Build the post-tick time; the bytes outside the chain hold their values.
    always_comb begin
        next_t = time_q;
        for (int i = 0; i < N_CHAIN; i++)
            next_t[i] = rolled[i];
        next_t[POS_DOW] = dow_next;
    end

    // Time register: a load wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            time_q <= RST_TIME;
        else if (load)
            time_q <= load_val;
        else if (tick)
            time_q <= next_t;
    end

    p_load_over_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && tick) |=> (time_q == $past(load_val)));

    p_month_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (time_q[POS_MON] == $past(time_q[POS_MON])) &&
                  (time_q[POS_YEAR] == $past(time_q[POS_YEAR])) &&
                  (time_q[POS_CENT] == $past(time_q[POS_CENT])));
endmodule

// File: rtl/tks_stage_buf.sv
`timescale 1ns/1ps
// tks_stage_buf: the write staging buffer. An open write starts with a copy of
// the live time and takes per-byte overwrites. The write closes on a valid stop
// or an abort. Assumes single-cycle strobes; a start wins over everything else.
module tks_stage_buf
    import tks_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  tbyte_t           data,
    input  logic             close,
    input  ttime_t           live_in,
    output logic             active_q,
    output ttime_t           stage_q
);
    // Open flag and buffer contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            stage_q  <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            stage_q  <= live_in;
        end else if (close) begin
            active_q <= 1'b0;
        end else if (wr && active_q) begin
            stage_q[idx] <= data;
        end
    end

    p_byte_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && wr && !start && !close) |=> (stage_q[$past(idx)] == $past(data)));

    p_stage_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !wr) |=> $stable(stage_q));
endmodule

// File: rtl/tks_snap_latch.sv
`timescale 1ns/1ps
// tks_snap_latch: the frozen read copy of the time, with a byte select for
// readout. Assumes the bus engine pulses the capture once per read command.
module tks_snap_latch
    import tks_pkg::*;
#(
    parameter ttime_t RST_TIME = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  ttime_t           live_in,
    input  logic [IDX_W-1:0] sel,
    output tbyte_t           rd_data
);
    ttime_t snap_q;

    // Capture register: changes only on a capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= RST_TIME;
        else if (cap)
            snap_q <= live_in;
    end

    // Byte readout.
    assign rd_data = snap_q[sel];

    p_snap_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (snap_q == $past(live_in)));

    p_snap_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(snap_q));
endmodule

// File: rtl/tkeep_shadow.sv
`timescale 1ns/1ps
// tkeep_shadow: a coherent shadow for the time registers. Reads use a frozen
// snapshot. Writes go through a staging buffer that commits in one cycle on a
// valid stop while the write-enable latch is set. The live counter keeps
// counting during every transaction. Assumes the strobes are single-cycle
// pulses from the bus engine.
module tkeep_shadow
    import tks_pkg::*;
#(
    parameter tbyte_t DAY_HI        = 8'h31,
    parameter tbyte_t DOW_HI        = 8'h06,
    parameter tbyte_t RESET_CENTURY = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_latch,
    input  logic              wr_start,
    input  logic              wr_byte,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_stop_ok,
    input  logic              wr_abort,
    input  logic              wr_enable,
    input  logic              tick_1s,
    input  logic [IDX_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic [TIME_W-1:0] live_time
);
    // Bytes 7..0: century, dow, year, month, day, hour, min, sec.
    localparam ttime_t RST_TIME = {RESET_CENTURY, 8'h00, 8'h00, 8'h01,
                                   8'h01, 8'h00, 8'h00, 8'h00};

    ttime_t live_q;
    ttime_t stage_q;
    logic   stage_open;
    logic   commit;

    // Commit only a write that is open, ends with a valid stop and is write-enabled.
    assign commit = wr_stop_ok && stage_open && wr_enable;

    tks_live_ctr #(
        .DAY_HI   (DAY_HI),
        .DOW_HI   (DOW_HI),
        .RST_TIME (RST_TIME)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1s),
        .load     (commit),
        .load_val (stage_q),
        .time_q   (live_q)
    );

    tks_stage_buf u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (wr_start),
        .wr       (wr_byte),
        .idx      (wr_idx),
        .data     (wr_data),
        .close    (wr_stop_ok || wr_abort),
        .live_in  (live_q),
        .active_q (stage_open),
        .stage_q  (stage_q)
    );

    tks_snap_latch #(
        .RST_TIME (RST_TIME)
    ) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (rd_latch),
        .live_in (live_q),
        .sel     (rd_sel),
        .rd_data (rd_data)
    );

    assign live_time = live_q;

    p_commit_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (live_q == $past(stage_q)));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1s && !(wr_stop_ok && wr_enable)) |=> $stable(live_q));

    p_abort_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_abort && !wr_start) |=> !stage_open);

    p_no_wel_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stop_ok && !wr_enable && !wr_start) |=> !stage_open);

    p_stray_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stage_open && !tick_1s) |=> $stable(live_q));
endmodule

// File: tb/tkeep_shadow_bench.sv
`timescale 1ns/1ps
module tkeep_shadow_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_latch = 1'b0, wr_start = 1'b0, wr_byte = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_stop_ok = 1'b0, wr_abort = 1'b0, wr_enable = 1'b1, tick_1s = 1'b0;
    logic [2:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic [63:0] live_time;

    int checks = 0;
    int errors = 0;
    logic [63:0] model;
    logic [63:0] held;

    always #4 clk = ~clk;

    tkeep_shadow u_tkeep_shadow (
        .clk(clk), .rst_n(rst_n), .rd_latch(rd_latch), .wr_start(wr_start),
        .wr_byte(wr_byte), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_stop_ok(wr_stop_ok), .wr_abort(wr_abort), .wr_enable(wr_enable),
        .tick_1s(tick_1s), .rd_sel(rd_sel), .rd_data(rd_data), .live_time(live_time)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] put(input logic [63:0] t, input int i, input logic [7:0] b);
        logic [63:0] r = t;
        r[8*i +: 8] = b;
        return r;
    endfunction

    // All helpers begin and end just after a falling edge.
    task automatic do_tick();
        tick_1s = 1'b1; @(negedge clk); tick_1s = 1'b0;
    endtask
    task automatic do_start();
        wr_start = 1'b1; @(negedge clk); wr_start = 1'b0;
    endtask
    task automatic do_byte(input int i, input logic [7:0] d);
        wr_byte = 1'b1; wr_idx = 3'(i); wr_data = d; @(negedge clk); wr_byte = 1'b0;
    endtask
    task automatic do_stop();
        wr_stop_ok = 1'b1; @(negedge clk); wr_stop_ok = 1'b0;
    endtask
    task automatic read_byte(input string req, input int i, input logic [7:0] exp);
        rd_sel = 3'(i); #1; check(req, {56'h0, rd_data}, {56'h0, exp});
    endtask

    task automatic t_reset();
        model = 64'h2000000101000000;
        check("R11 live after reset", live_time, model);
        read_byte("R11 snapshot century after reset", 7, 8'h20);
        read_byte("R11 snapshot day after reset", 3, 8'h01);
    endtask

    task automatic t_count();
        repeat (3) do_tick();
        model = put(model, 0, 8'h03);
        check("R3 seconds after three ticks", live_time, model);
    endtask

    task automatic t_snapshot();
        rd_latch = 1'b1; @(negedge clk); rd_latch = 1'b0;
        read_byte("R1 snapshot seconds", 0, 8'h03);
        repeat (2) do_tick();
        model = put(model, 0, 8'h05);
        check("R3 live advances during read", live_time, model);
        read_byte("R2 snapshot held after ticks", 0, 8'h03);
        read_byte("R1 snapshot month", 4, 8'h01);
    endtask

    task automatic t_rollover();
        do_start();
        do_byte(0, 8'h59); do_byte(1, 8'h59); do_byte(2, 8'h23);
        do_byte(3, 8'h31); do_byte(6, 8'h06);
        do_stop();
        model = 64'h2006000131235959;
        check("R6 full commit", live_time, model);
        do_tick();
        model = 64'h2000000101000000;
        check("R4 full wrap of chain", live_time, model);
        do_start(); do_byte(0, 8'h59); do_byte(1, 8'h05); do_stop();
        do_tick();
        model = put(model, 1, 8'h06);
        check("R4 minute carry only", live_time, model);
    endtask

    task automatic t_single();
        do_start(); do_byte(4, 8'h12); do_stop();
        model = put(model, 4, 8'h12);
        check("R5 single byte write", live_time, model);
    endtask

    task automatic t_write_tick();
        held = model;
        do_start();
        repeat (2) do_tick();
        check("R3 live counts during write", live_time, put(model, 0, 8'h02));
        do_byte(5, 8'h24); do_stop();
        model = put(held, 5, 8'h24);
        check("R5 unwritten bytes restored from start copy", live_time, model);
    endtask

    task automatic t_abort();
        do_start(); do_byte(0, 8'h45);
        wr_abort = 1'b1; @(negedge clk); wr_abort = 1'b0;
        check("R7 abort leaves live", live_time, model);
        do_stop();
        check("R7 stop after abort no commit", live_time, model);
    endtask

    task automatic t_no_wel();
        do_start(); do_byte(1, 8'h33);
        wr_enable = 1'b0; do_stop(); wr_enable = 1'b1;
        check("R8 no commit without enable", live_time, model);
        do_stop();
        check("R8 buffer discarded", live_time, model);
    endtask

    task automatic t_commit_tick();
        do_start(); do_byte(0, 8'h10);
        wr_stop_ok = 1'b1; tick_1s = 1'b1; @(negedge clk);
        wr_stop_ok = 1'b0; tick_1s = 1'b0;
        model = put(model, 0, 8'h10);
        check("R9 commit wins over tick", live_time, model);
        do_tick();
        model = put(model, 0, 8'h11);
        check("R9 next tick from loaded value", live_time, model);
    endtask

    task automatic t_stray();
        do_byte(0, 8'h55); do_stop();
        check("R10 stray byte and stop ignored", live_time, model);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_snapshot();
        t_rollover();
        t_single();
        t_write_tick();
        t_abort();
        t_no_wel();
        t_commit_tick();
        t_stray();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule